// File: doc/BRIEF.md
# Predicated Vector Dual Multiply-Accumulate Unit

This block reduces two 128-bit vectors into a single 32-bit scalar. It multiplies each element of the first vector by the element at the same position in the second vector, and sums the products into one 32-bit result. The caller picks three things: the element width (8, 16 or 32 bits), whether elements are signed or unsigned, and three modifiers. The first modifier makes odd-position products subtract instead of add. The second pairs each element of the first vector with its neighbour. The third makes the sum start from a supplied accumulator instead of zero.

A per-byte predicate mask switches individual elements in or out of the sum. The unit takes one request per cycle on a start strobe. The result is registered and a done pulse comes one clock later. An illegal-operation flag reports an unsupported combination, and such a request leaves the result register unchanged.

Top module: `vdmac_unit`

## Requirements
- R1: `elem_size` selects the element width: 0 gives 8 bits (16 elements), 1 gives 16 bits (8 elements) and 2 gives 32 bits (4 elements). Element k sits in bits [k*W +: W] of each vector.
- R2: An element of width W bytes at index k takes part in the sum only when `pred[k*W]` is 1. The other mask bits of its byte group have no effect.
- R3: All products and sums wrap modulo 2^32.
- R4: Products at even element indices are always added. Products at odd indices are added when `sub_odd`=0 and subtracted when `sub_odd`=1.
- R5: When `exchange`=1, element k of `vec_b` is multiplied by element k XOR 1 of `vec_a` (the neighbour in its pair) instead of element k.
- R6: When `is_signed`=1, elements are sign-extended before multiplying. When `is_signed`=0, they are zero-extended.
- R7: An unsigned request with `sub_odd`=1 or `exchange`=1 is illegal. It raises `illegal` with `done` and leaves `result` unchanged.
- R8: The starting value of the sum is `acc_in` when `accumulate`=1 or `skip_first`=1, and zero otherwise.
- R9: `elem_size`=3 is reserved. It raises `illegal` with `done` and leaves `result` unchanged.
- R10: `done` is high in exactly the cycle after a cycle with `start`=1 and low otherwise. `result` holds its value while `start`=0.
- R11: A synchronous active-high `rst` clears `result`, `done` and `illegal`.
- R12: With an all-zero `pred`, a legal request produces exactly the starting value from R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one operation per cycle |
| elem_size | input | 2 | Element width code |
| is_signed | input | 1 | Signed element interpretation |
| sub_odd | input | 1 | Subtract odd-index products |
| exchange | input | 1 | Pair elements with their neighbour |
| accumulate | input | 1 | Start from `acc_in` |
| skip_first | input | 1 | Also start from `acc_in` |
| vec_a | input | 128 | First vector operand |
| vec_b | input | 128 | Second vector operand |
| pred | input | 16 | Per-byte predicate mask |
| acc_in | input | 32 | Scalar accumulator input |
| result | output | 32 | Registered scalar result |
| done | output | 1 | Pulse one cycle after start |
| illegal | output | 1 | Pulse with done for an unsupported request |

## Verification
The hardest case to expose is a wrong lane choice. This covers predicate bits that sit inside an element's byte group but not at its lowest byte, and exchange pairing for the 16- and 32-bit sizes. A plain sum can hide either mistake. The stimulus therefore uses masks with only the upper bits of a group set, and operand patterns in which each element's value is unique, so a swapped or wrongly gated lane shifts the result visibly. Illegal requests are issued right after a legal one with a known result, so that any update of the held value is seen.

// File: rtl/vdmac_pkg.sv
package vdmac_pkg;
    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_RSVD = 2'd3
    } esize_e;

    localparam int ACC_W = 32;

    typedef struct packed {
        logic [ACC_W-1:0] result;
        logic             done;
        logic             illegal;
    } vdmac_state_t;
endpackage

// File: rtl/vdmac_elem_term.sv
module vdmac_elem_term #(
    parameter int EW    = 8,
    parameter int ACC_W = 32
) (
    input  logic [EW-1:0]    a_el,
    input  logic [EW-1:0]    b_el,
    input  logic             is_signed,
    input  logic             negate,
    input  logic             enable,
    output logic [ACC_W-1:0] term
);
    logic [ACC_W-1:0] ext_a;
    logic [ACC_W-1:0] ext_b;
    logic [ACC_W-1:0] prod;

    generate
        if (EW < ACC_W) begin : g_extend
            localparam int PAD = ACC_W - EW;
            assign ext_a = {{PAD{is_signed & a_el[EW-1]}}, a_el};
            assign ext_b = {{PAD{is_signed & b_el[EW-1]}}, b_el};
        end else begin : g_full
            logic unused_sgn;
            assign unused_sgn = is_signed;
            assign ext_a = a_el[ACC_W-1:0];
            assign ext_b = b_el[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        prod = ext_a * ext_b;
        if (!enable) begin
            term = '0;
        end else if (negate) begin
            term = '0 - prod;
        end else begin
            term = prod;
        end
    end
endmodule

// File: rtl/vdmac_size_sum.sv
module vdmac_size_sum #(
    parameter int EW    = 8,
    parameter int VEC_W = 128,
    parameter int ACC_W = 32
) (
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    input  logic [VEC_W/8-1:0] pred,
    input  logic               is_signed,
    input  logic               sub_odd,
    input  logic               exchange,
    output logic [ACC_W-1:0]   sum
);
    localparam int NE = VEC_W / EW;
    localparam int NB = EW / 8;

    logic [ACC_W-1:0] terms [NE];
    logic             unused_pred;
    assign unused_pred = ^pred;

    genvar e;
    generate
        for (e = 0; e < NE; e++) begin : g_el
            localparam int PARTNER = e ^ 1;
            localparam bit ODD     = (e % 2) == 1;
            logic [EW-1:0] a_pick;
            logic          neg;
            assign a_pick = exchange ? vec_a[PARTNER*EW +: EW] : vec_a[e*EW +: EW];
            assign neg    = ODD & sub_odd;
            vdmac_elem_term #(.EW(EW), .ACC_W(ACC_W)) term_i (
                .a_el      (a_pick),
                .b_el      (vec_b[e*EW +: EW]),
                .is_signed (is_signed),
                .negate    (neg),
                .enable    (pred[e*NB]),
                .term      (terms[e])
            );
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int k = 0; k < NE; k++) begin
            sum = sum + terms[k];
        end
    end
endmodule

// File: rtl/vdmac_decode.sv
module vdmac_decode
    import vdmac_pkg::*;
(
    input  logic [1:0] elem_size,
    input  logic       is_signed,
    input  logic       sub_odd,
    input  logic       exchange,
    input  logic       accumulate,
    input  logic       skip_first,
    output logic       bad_op,
    output logic       use_acc
);
    always_comb begin
        bad_op  = (esize_e'(elem_size) == ESZ_RSVD) || (!is_signed && (sub_odd || exchange));
        use_acc = accumulate || skip_first;
    end
endmodule

// File: rtl/vdmac_unit.sv
module vdmac_unit
    import vdmac_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         elem_size,
    input  logic               is_signed,
    input  logic               sub_odd,
    input  logic               exchange,
    input  logic               accumulate,
    input  logic               skip_first,
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    input  logic [VEC_W/8-1:0] pred,
    input  logic [ACC_W-1:0]   acc_in,
    output logic [ACC_W-1:0]   result,
    output logic               done,
    output logic               illegal
);
    localparam int NSIZES = 3;

    logic [ACC_W-1:0] size_sum [NSIZES];
    logic [ACC_W-1:0] sel_sum;
    logic [ACC_W-1:0] init_val;
    logic             bad_op;
    logic             use_acc;
    vdmac_state_t     state_d;
    vdmac_state_t     state_q;

    vdmac_decode dec_i (
        .elem_size  (elem_size),
        .is_signed  (is_signed),
        .sub_odd    (sub_odd),
        .exchange   (exchange),
        .accumulate (accumulate),
        .skip_first (skip_first),
        .bad_op     (bad_op),
        .use_acc    (use_acc)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NSIZES; gi++) begin : g_sz
            vdmac_size_sum #(.EW(8 << gi), .VEC_W(VEC_W), .ACC_W(ACC_W)) sum_i (
                .vec_a     (vec_a),
                .vec_b     (vec_b),
                .pred      (pred),
                .is_signed (is_signed),
                .sub_odd   (sub_odd),
                .exchange  (exchange),
                .sum       (size_sum[gi])
            );
        end
    endgenerate

    always_comb begin
        case (esize_e'(elem_size))
            ESZ_BYTE: sel_sum = size_sum[0];
            ESZ_HALF: sel_sum = size_sum[1];
            ESZ_WORD: sel_sum = size_sum[2];
            default:  sel_sum = '0;
        endcase
        init_val = use_acc ? acc_in : '0;

        state_d         = state_q;
        state_d.done    = start;
        state_d.illegal = start && bad_op;
        if (start && !bad_op) begin
            state_d.result = init_val + sel_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result  = state_q.result;
    assign done    = state_q.done;
    assign illegal = state_q.illegal;
endmodule

// File: rtl/vdmac_unit_chk.sv
module vdmac_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  elem_size,
    input logic        is_signed,
    input logic        sub_odd,
    input logic        exchange,
    input logic        accumulate,
    input logic        skip_first,
    input logic [15:0] pred,
    input logic [31:0] acc_in,
    input logic [31:0] result,
    input logic        done,
    input logic        illegal
);
    logic req_bad;
    assign req_bad = (elem_size == 2'd3) || (!is_signed && (sub_odd || exchange));

    a_r10_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && $stable(result));

    a_r7_r9_illegal_keeps_result: assert property (@(posedge clk) disable iff (rst)
        start && req_bad |=> illegal && $stable(result));

    a_r10_illegal_only_with_done: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    a_r12_empty_mask_init: assert property (@(posedge clk) disable iff (rst)
        start && !req_bad && pred == 16'h0 |=>
            result == (($past(accumulate) || $past(skip_first)) ? $past(acc_in) : 32'h0));
endmodule

bind vdmac_unit vdmac_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .elem_size  (elem_size),
    .is_signed  (is_signed),
    .sub_odd    (sub_odd),
    .exchange   (exchange),
    .accumulate (accumulate),
    .skip_first (skip_first),
    .pred       (pred),
    .acc_in     (acc_in),
    .result     (result),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/vdmac_unit_tb_top.sv
`timescale 1ns/1ps
module vdmac_unit_tb_top;
    typedef struct packed {
        logic [1:0]   sz;
        logic         sgn;
        logic         sub;
        logic         xch;
        logic         acc;
        logic         skp;
        logic [127:0] a;
        logic [127:0] b;
        logic [15:0]  p;
        logic [31:0]  ai;
    } stim_t;

    localparam int NVEC = 10;
    localparam stim_t VECS [NVEC] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 128'h0f0e0d0c0b0a09080706050403020100, 128'h01010101010101010101010101010101, 16'hffff, 32'h0},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 128'hf1e2d3c4b5a6978879695a4b3c2d1e0f, 128'h8091a2b3c4d5e6f7081928374655647f, 16'ha5c3, 32'h12345678},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 128'hffeeddccbbaa99887766554433221100, 128'hffffffffffffffffffffffffffffffff, 16'hffff, 32'h0},
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 128'h0102030405060708090a0b0c0d0e0f10, 128'h100f0e0d0c0b0a090807060504030201, 16'h00ff, 32'h00000100},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 128'h8000_7fff_1234_fedc_0001_ffff_4000_c000, 128'h0003_0005_0007_0009_000b_000d_000f_0011, 16'h5555, 32'h0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 128'h0008_0007_0006_0005_0004_0003_0002_0001, 128'h0100_0200_0300_0400_0500_0600_0700_0800, 16'haaaa, 32'hfffffff0},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 128'hffff_ffff_0001_0002_8000_8000_0003_0004, 128'hffff_0002_ffff_0003_0002_0002_0005_0006, 16'hffff, 32'h0},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 128'h00000004_00000003_00000002_00000001, 128'h00000040_00000030_00000020_00000010, 16'h1111, 32'h0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 128'h89abcdef_12345678_fedcba98_76543210, 128'h0f0f0f0f_f0f0f0f0_33333333_cccccccc, 16'heeee, 32'h00000007},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 128'hffffffff_80000000_00010000_00000002, 128'hffffffff_00000002_00010000_00000003, 16'hffff, 32'h00000010}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   elem_size = '0;
    logic         is_signed = 1'b0;
    logic         sub_odd = 1'b0;
    logic         exchange = 1'b0;
    logic         accumulate = 1'b0;
    logic         skip_first = 1'b0;
    logic [127:0] vec_a = '0;
    logic [127:0] vec_b = '0;
    logic [15:0]  pred = '0;
    logic [31:0]  acc_in = '0;
    logic [31:0]  result;
    logic         done;
    logic         illegal;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    vdmac_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .elem_size(elem_size),
        .is_signed(is_signed), .sub_odd(sub_odd), .exchange(exchange),
        .accumulate(accumulate), .skip_first(skip_first),
        .vec_a(vec_a), .vec_b(vec_b), .pred(pred), .acc_in(acc_in),
        .result(result), .done(done), .illegal(illegal)
    );

    function automatic logic [31:0] model(input stim_t s);
        int nb = 1 << s.sz;
        int ne = 16 / nb;
        logic [31:0] sum = (s.acc || s.skp) ? s.ai : 32'h0;
        for (int e = 0; e < ne; e++) begin
            if (s.p[e*nb]) begin
                int src = s.xch ? (e ^ 1) : e;
                logic [127:0] ra = s.a >> (src * nb * 8);
                logic [127:0] rb = s.b >> (e * nb * 8);
                logic [31:0] xa;
                logic [31:0] xb;
                logic [31:0] pr;
                case (s.sz)
                    2'd0: begin
                        xa = s.sgn ? 32'(signed'(ra[7:0])) : 32'(ra[7:0]);
                        xb = s.sgn ? 32'(signed'(rb[7:0])) : 32'(rb[7:0]);
                    end
                    2'd1: begin
                        xa = s.sgn ? 32'(signed'(ra[15:0])) : 32'(ra[15:0]);
                        xb = s.sgn ? 32'(signed'(rb[15:0])) : 32'(rb[15:0]);
                    end
                    default: begin
                        xa = ra[31:0];
                        xb = rb[31:0];
                    end
                endcase
                pr = xa * xb;
                if ((e % 2 == 1) && s.sub) sum = sum - pr;
                else sum = sum + pr;
            end
        end
        return sum;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input stim_t s);
        @(negedge clk);
        elem_size = s.sz; is_signed = s.sgn; sub_odd = s.sub; exchange = s.xch;
        accumulate = s.acc; skip_first = s.skp; vec_a = s.a; vec_b = s.b;
        pred = s.p; acc_in = s.ai; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic stim_t mk(input logic [1:0] sz, input logic sgn, input logic sub,
                                 input logic xch, input logic acc, input logic [127:0] a,
                                 input logic [127:0] b, input logic [15:0] p, input logic [31:0] ai);
        stim_t s;
        s.sz = sz; s.sgn = sgn; s.sub = sub; s.xch = xch; s.acc = acc; s.skp = 1'b0;
        s.a = a; s.b = b; s.p = p; s.ai = ai;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        stim_t s;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 result after reset", result, 32'h0);
        check("R11 done after reset", {31'b0, done}, 32'h0);
        check("R11 illegal after reset", {31'b0, illegal}, 32'h0);
        rst = 1'b0;

        // R1 R2 R4 R5 R6 R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i]);
            check($sformatf("R1 R2 R4 R5 R6 R8 vector %0d", i), result, model(VECS[i]));
            check("R10 done pulse", {31'b0, done}, 32'h1);
            check("R10 legal not flagged", {31'b0, illegal}, 32'h0);
        end
        @(negedge clk);
        check("R10 done drops", {31'b0, done}, 32'h0);

        // R4 R6: hand values, bytes -1,2 times 3,4
        issue(mk(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 128'h02ff, 128'h0403, 16'h0003, 32'h0));
        check("R4 signed subtract odd", result, 32'hfffffff5);
        issue(mk(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 128'h02ff, 128'h0403, 16'h0003, 32'h0));
        check("R6 unsigned add", result, 32'h00000305);
        // R5: exchange on halves: a0=2,a1=3 b0=10,b1=100 -> 3*10+2*100
        issue(mk(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 128'h0003_0002, 128'h0064_000a, 16'h0005, 32'h0));
        check("R5 exchange pairs", result, 32'd230);
        // R2: only upper bits of word groups set -> nothing enabled
        issue(mk(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, {4{32'h7}}, {4{32'h9}}, 16'heeee, 32'h00000042));
        check("R2 non-lowest mask bits ignored", result, 32'h00000042);
        // R3: 0x10000*0x10000 wraps to 0, plus 5
        issue(mk(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 128'h00010000, 128'h00010000, 16'h0001, 32'h5));
        check("R3 wrap", result, 32'h00000005);
        // R12: zero mask, accumulate clear -> 0 ; via skip_first -> acc_in
        issue(mk(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, {16{8'h11}}, {16{8'h22}}, 16'h0, 32'hdeadbeef));
        check("R12 R8 zero mask zero init", result, 32'h0);
        s = mk(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, {8{16'h11}}, {8{16'h22}}, 16'h0, 32'hcafef00d);
        s.skp = 1'b1;
        issue(s);
        check("R12 R8 skip_first init", result, 32'hcafef00d);
        held = result;

        // R9: reserved size
        issue(mk(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, {16{8'h5}}, {16{8'h6}}, 16'hffff, 32'h1));
        check("R9 flag", {31'b0, illegal}, 32'h1);
        check("R9 result held", result, held);
        // R7: unsigned with subtract, unsigned with exchange
        issue(mk(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, {16{8'h5}}, {16{8'h6}}, 16'hffff, 32'h0));
        check("R7 unsigned subtract flag", {31'b0, illegal}, 32'h1);
        check("R7 unsigned subtract held", result, held);
        issue(mk(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, {16{8'h5}}, {16{8'h6}}, 16'hffff, 32'h0));
        check("R7 unsigned exchange flag", {31'b0, illegal}, 32'h1);
        check("R7 unsigned exchange held", result, held);
        @(negedge clk);
        check("R10 illegal drops", {31'b0, illegal}, 32'h0);

        // R11: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R11 reset clears result", result, 32'h0);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule